// File: doc/BRIEF.md
# Display Mirror Park Sequencer

This block sits on the host side of a micromirror display controller and drives that controller's park and reset lines. It carries out three operations. A planned power-down parks the mirrors, waits for the controller to drop its power-enable output and then raises a flag that tells the system that supplies may be removed. A park-and-restart parks the mirrors, pulses the controller reset while the mirrors stay parked and then unparks. An unplanned loss of input power drops the power-good indication to the controller and requests a hold-up of the supplies for the whole park window.

All windows are counted in clock cycles. The cycle counts come from a clock-frequency parameter and are rounded up, so every minimum time holds at any frequency. The asynchronous inputs, power-fail and the controller's power-enable, pass through synchronizer stages before the sequencer acts on them. A planned power-down ends in a held state that only a system reset leaves. That state is either "safe to remove" or, when power-enable never drops, "error".

Top module: `mirrorParkSeq`

## Requirements
- R1: After system reset, `parkN` and `ctrlRstN` are high, `pwrGood` is high, and `safeToRemove`, `holdUp`, `busy` and `errFlag` are low.
- R2: A `reqPowerDown` strobe (active high, one cycle, sampled at a rising clock edge) drives `parkN` low. `parkN` then stays low at least PARK_CYC cycles and stays low until the next system reset.
- R3: `safeToRemove` rises only after the full park window has elapsed and the synchronized `ctrlPwrEn` has been seen low. Once high, it stays high until system reset.
- R4: A `reqRestart` strobe drives `parkN` low for PARK_CYC cycles. `ctrlRstN` is then low for exactly RESET_CYC cycles, `ctrlRstN` is released, and `parkN` is released one cycle later. `parkN` is therefore low for PARK_CYC+RESET_CYC+1 cycles.
- R5: `parkN` is never high while `ctrlRstN` is low. `parkN` is never released in the same cycle that `ctrlRstN` is released.
- R6: While `busy` is high, `reqPowerDown` and `reqRestart` are ignored. When both strobes arrive in the idle state together, power-down is taken.
- R7: A synchronized rising `powerFail` aborts any sequence in progress. It drives `parkN` low and drops `pwrGood`, and `pwrGood` stays low until system reset. It raises `holdUp` for exactly PARK_CYC cycles, and the block then waits for power-enable to drop as in a planned power-down.
- R8: If `ctrlPwrEn` is still high TIMEOUT_CYC cycles after the park window ends, `errFlag` rises and stays high until system reset. `safeToRemove` stays low from then on, even if `ctrlPwrEn` drops later.
- R9: PARK_CYC = ceil(CLK_HZ x 500 / 10^6) and RESET_CYC = ceil(CLK_HZ x 50000 / 10^6). For example, CLK_HZ = 100003 gives 51 and 5001.
- R10: `busy` is high during every timed or waiting phase. It is low in idle and in the held safe and error states.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low system reset |
| reqPowerDown | input | 1 | Strobe: start planned power-down |
| reqRestart | input | 1 | Strobe: start park-and-restart |
| powerFail | input | 1 | Asynchronous input-power-loss detect, active high |
| ctrlPwrEn | input | 1 | Controller's power-enable output, asynchronous |
| parkN | output | 1 | Active-low park line to controller |
| ctrlRstN | output | 1 | Active-low controller reset |
| pwrGood | output | 1 | Power-good indication to controller, low after a power failure |
| holdUp | output | 1 | Request to hold supplies up during the park window |
| safeToRemove | output | 1 | Power may now be removed |
| busy | output | 1 | A sequence is in progress |
| errFlag | output | 1 | Sticky: power-enable did not drop in time |

## Verification
The hardest situation to reach is a power failure that arrives part-way through a sequence that is already running. The bench starts a planned power-down with power-enable still high and raises `powerFail` inside the park window. It then counts the `holdUp` cycles, confirms that `pwrGood` stays low, and only afterwards drops power-enable to release the safe flag. A restart is also loaded with both request strobes during its long reset phase. The scoreboard, which holds exactly one expected pulse per line, reports any extra park or reset pulse.

// File: rtl/parkSeqPkg.sv
package parkSeqPkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_PD_PARK,
    ST_PWR_WAIT,
    ST_DONE,
    ST_ERR,
    ST_RS_PARK,
    ST_RS_RESET,
    ST_RS_RELEASE,
    ST_PF_HOLD
  } seqState_e;

  typedef struct packed {
    logic loadPark;
    logic loadReset;
    logic loadTimeout;
  } timerCmd_t;

  function automatic longint unsigned ceilCycles(longint unsigned hz, longint unsigned us);
    return (hz * us + 64'd999_999) / 64'd1_000_000;
  endfunction

endpackage

// File: rtl/parkSeqTimer.sv
module parkSeqTimer #(
  parameter int unsigned PARK_CYC    = 25000,
  parameter int unsigned RESET_CYC   = 2500000,
  parameter int unsigned TIMEOUT_CYC = 10000,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  parkSeqPkg::timerCmd_t cmd,
  input  logic                  powerFail,
  input  logic                  ctrlPwrEn,
  output logic                  expired,
  output logic                  pfSync,
  output logic                  pwrEnSync
);
  localparam int unsigned MAX_AB = (PARK_CYC > RESET_CYC) ? PARK_CYC : RESET_CYC;
  localparam int unsigned MAX_C  = (MAX_AB > TIMEOUT_CYC) ? MAX_AB : TIMEOUT_CYC;
  localparam int unsigned CW     = $clog2(MAX_C + 1);

  logic [CW-1:0] cnt;

  // shared down counter; a load places N-1 so the phase lasts N cycles
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt <= '0;
    end else if (cmd.loadPark) begin
      cnt <= CW'(PARK_CYC - 1);
    end else if (cmd.loadReset) begin
      cnt <= CW'(RESET_CYC - 1);
    end else if (cmd.loadTimeout) begin
      cnt <= CW'(TIMEOUT_CYC - 1);
    end else if (cnt != '0) begin
      cnt <= cnt - 1'b1;
    end
  end

  assign expired = (cnt == '0);

  // synchronizer chains for the two asynchronous inputs
  logic [SYNC_STAGES-1:0] pfChain;
  logic [SYNC_STAGES-1:0] peChain;

  generate
    genvar s;
    for (s = 0; s < SYNC_STAGES; s++) begin : gSync
      if (s == 0) begin : gFirst
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) begin
            pfChain[0] <= 1'b0;
            peChain[0] <= 1'b1;
          end else begin
            pfChain[0] <= powerFail;
            peChain[0] <= ctrlPwrEn;
          end
        end
      end else begin : gNext
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) begin
            pfChain[s] <= 1'b0;
            peChain[s] <= 1'b1;
          end else begin
            pfChain[s] <= pfChain[s-1];
            peChain[s] <= peChain[s-1];
          end
        end
      end
    end
  endgenerate

  assign pfSync    = pfChain[SYNC_STAGES-1];
  assign pwrEnSync = peChain[SYNC_STAGES-1];
endmodule

// File: rtl/parkSeqCtrl.sv
module parkSeqCtrl (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  reqPowerDown,
  input  logic                  reqRestart,
  input  logic                  expired,
  input  logic                  pfSync,
  input  logic                  pwrEnSync,
  output parkSeqPkg::timerCmd_t cmd,
  output logic                  parkN,
  output logic                  ctrlRstN,
  output logic                  pwrGood,
  output logic                  holdUp,
  output logic                  safeToRemove,
  output logic                  busy,
  output logic                  errFlag
);
  import parkSeqPkg::*;

  seqState_e state, stateNext;
  logic      pfLatched;
  logic      pfTrig;
  logic      terminal;

  assign terminal = (state == ST_DONE) || (state == ST_ERR);
  assign pfTrig   = pfSync && !pfLatched && !terminal;

  always_comb begin
    cmd       = '0;
    stateNext = state;
    if (pfTrig) begin
      stateNext    = ST_PF_HOLD;
      cmd.loadPark = 1'b1;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (reqPowerDown) begin
            stateNext    = ST_PD_PARK;
            cmd.loadPark = 1'b1;
          end else if (reqRestart) begin
            stateNext    = ST_RS_PARK;
            cmd.loadPark = 1'b1;
          end
        end
        ST_PD_PARK, ST_PF_HOLD: begin
          if (expired) begin
            stateNext       = ST_PWR_WAIT;
            cmd.loadTimeout = 1'b1;
          end
        end
        ST_PWR_WAIT: begin
          if (!pwrEnSync)   stateNext = ST_DONE;
          else if (expired) stateNext = ST_ERR;
        end
        ST_RS_PARK: begin
          if (expired) begin
            stateNext     = ST_RS_RESET;
            cmd.loadReset = 1'b1;
          end
        end
        ST_RS_RESET: begin
          if (expired) stateNext = ST_RS_RELEASE;
        end
        ST_RS_RELEASE: stateNext = ST_IDLE;
        ST_DONE, ST_ERR: stateNext = state;
        default: stateNext = ST_IDLE;
      endcase
    end
  end

  // state and registered pin outputs, all decoded from the next state
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state        <= ST_IDLE;
      pfLatched    <= 1'b0;
      parkN        <= 1'b1;
      ctrlRstN     <= 1'b1;
      pwrGood      <= 1'b1;
      holdUp       <= 1'b0;
      safeToRemove <= 1'b0;
      busy         <= 1'b0;
      errFlag      <= 1'b0;
    end else begin
      state        <= stateNext;
      pfLatched    <= pfLatched | pfSync;
      pwrGood      <= !(pfLatched | pfSync);
      parkN        <= (stateNext == ST_IDLE);
      ctrlRstN     <= (stateNext != ST_RS_RESET);
      holdUp       <= (stateNext == ST_PF_HOLD);
      safeToRemove <= (stateNext == ST_DONE) && !errFlag;
      busy         <= !((stateNext == ST_IDLE) || (stateNext == ST_DONE) ||
                        (stateNext == ST_ERR));
      errFlag      <= errFlag | (stateNext == ST_ERR);
    end
  end
endmodule

// File: rtl/mirrorParkSeq.sv
module mirrorParkSeq #(
  parameter int unsigned CLK_HZ          = 50_000_000,
  parameter int unsigned PARK_US         = 500,
  parameter int unsigned RESET_US        = 50_000,
  parameter int unsigned PWR_TIMEOUT_CYC = 10_000,
  parameter int unsigned SYNC_STAGES     = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic reqPowerDown,
  input  logic reqRestart,
  input  logic powerFail,
  input  logic ctrlPwrEn,
  output logic parkN,
  output logic ctrlRstN,
  output logic pwrGood,
  output logic holdUp,
  output logic safeToRemove,
  output logic busy,
  output logic errFlag
);
  import parkSeqPkg::*;

  localparam int unsigned PARK_CYC  = int'(ceilCycles(64'(CLK_HZ), 64'(PARK_US)));
  localparam int unsigned RESET_CYC = int'(ceilCycles(64'(CLK_HZ), 64'(RESET_US)));

  timerCmd_t cmd;
  logic      expired;
  logic      pfSync;
  logic      pwrEnSync;

  parkSeqTimer #(
    .PARK_CYC   (PARK_CYC),
    .RESET_CYC  (RESET_CYC),
    .TIMEOUT_CYC(PWR_TIMEOUT_CYC),
    .SYNC_STAGES(SYNC_STAGES)
  ) i_timer (
    .clk      (clk),
    .rstN     (rstN),
    .cmd      (cmd),
    .powerFail(powerFail),
    .ctrlPwrEn(ctrlPwrEn),
    .expired  (expired),
    .pfSync   (pfSync),
    .pwrEnSync(pwrEnSync)
  );

  parkSeqCtrl i_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .reqPowerDown(reqPowerDown),
    .reqRestart  (reqRestart),
    .expired     (expired),
    .pfSync      (pfSync),
    .pwrEnSync   (pwrEnSync),
    .cmd         (cmd),
    .parkN       (parkN),
    .ctrlRstN    (ctrlRstN),
    .pwrGood     (pwrGood),
    .holdUp      (holdUp),
    .safeToRemove(safeToRemove),
    .busy        (busy),
    .errFlag     (errFlag)
  );
endmodule

// File: rtl/mirrorParkSeqChk.sv
module mirrorParkSeqChk #(
  parameter int unsigned PARK_CYC = 25000
) (
  input logic clk,
  input logic rstN,
  input logic ctrlPwrEn,
  input logic parkN,
  input logic ctrlRstN,
  input logic pwrGood,
  input logic holdUp,
  input logic safeToRemove,
  input logic errFlag
);
  logic [31:0] lowCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                         lowCnt <= '0;
    else if (!parkN && lowCnt != '1)   lowCnt <= lowCnt + 1'b1;
    else if (parkN)                    lowCnt <= '0;
  end

  AST_PARK_MIN_WINDOW: assert property (@(posedge clk) disable iff (!rstN)
    $rose(parkN) |-> (lowCnt >= PARK_CYC)); // R2

  AST_PARK_COVERS_RESET: assert property (@(posedge clk) disable iff (!rstN)
    !ctrlRstN |-> !parkN); // R5

  AST_RELEASE_ORDER: assert property (@(posedge clk) disable iff (!rstN)
    $rose(parkN) |-> (ctrlRstN && $past(ctrlRstN))); // R4

  AST_SAFE_AFTER_PWREN: assert property (@(posedge clk) disable iff (!rstN)
    safeToRemove |-> (!parkN && !errFlag)); // R3

  AST_SAFE_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    safeToRemove |=> safeToRemove); // R3

  AST_PG_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    !pwrGood |=> !pwrGood); // R7

  AST_HOLDUP_PARKED: assert property (@(posedge clk) disable iff (!rstN)
    holdUp |-> (!parkN && !pwrGood)); // R7

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    errFlag |=> (errFlag && !safeToRemove)); // R8

  AST_SAFE_SEEN_LOW: assert property (@(posedge clk) disable iff (!rstN)
    $rose(safeToRemove) |-> !$past(ctrlPwrEn, 3)); // R3
endmodule

bind mirrorParkSeq mirrorParkSeqChk #(.PARK_CYC(PARK_CYC)) i_chk (
  .clk         (clk),
  .rstN        (rstN),
  .ctrlPwrEn   (ctrlPwrEn),
  .parkN       (parkN),
  .ctrlRstN    (ctrlRstN),
  .pwrGood     (pwrGood),
  .holdUp      (holdUp),
  .safeToRemove(safeToRemove),
  .errFlag     (errFlag)
);

// File: tb/test_mirrorParkSeq.sv
module test_mirrorParkSeq;
  localparam int unsigned HZ      = 100_003;
  localparam int unsigned TO_CYC  = 20;
  localparam longint PARK_EXP     = (longint'(HZ) * 500 + 999_999) / 1_000_000;
  localparam longint RESET_EXP    = (longint'(HZ) * 50_000 + 999_999) / 1_000_000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqPowerDown = 1'b0;
  logic reqRestart = 1'b0;
  logic powerFail = 1'b0;
  logic ctrlPwrEn = 1'b1;
  logic parkN, ctrlRstN, pwrGood, holdUp, safeToRemove, busy, errFlag;

  int total = 0;
  int bad = 0;
  bit finished = 0;
  int parkQ[$];
  int rstQ[$];

  always #10 clk = ~clk;

  mirrorParkSeq #(.CLK_HZ(HZ), .PWR_TIMEOUT_CYC(TO_CYC)) i_mirrorParkSeq (
    .clk(clk), .rstN(rstN), .reqPowerDown(reqPowerDown), .reqRestart(reqRestart),
    .powerFail(powerFail), .ctrlPwrEn(ctrlPwrEn), .parkN(parkN), .ctrlRstN(ctrlRstN),
    .pwrGood(pwrGood), .holdUp(holdUp), .safeToRemove(safeToRemove), .busy(busy),
    .errFlag(errFlag)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic waitCyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic pulse(input bit pd, input bit rs);
    @(negedge clk);
    reqPowerDown = pd;
    reqRestart   = rs;
    @(negedge clk);
    reqPowerDown = 1'b0;
    reqRestart   = 1'b0;
  endtask

  task automatic sysReset();
    @(negedge clk);
    rstN = 1'b0;
    powerFail = 1'b0;
    ctrlPwrEn = 1'b1;
    waitCyc(3);
    rstN = 1'b1;
    waitCyc(2);
  endtask

  task automatic waitIdle(input int limit);
    for (int i = 0; i < limit && busy; i++) @(negedge clk);
  endtask

  // scoreboard monitor: measures low pulses and compares with expected queue
  int pLow = 0;
  int rLow = 0;
  always @(negedge clk) begin
    if (!rstN) begin
      pLow = 0;
      rLow = 0;
    end else begin
      if (!parkN) pLow++;
      else if (pLow > 0) begin
        if (parkQ.size() == 0) check(0, "R6 unexpected park pulse", pLow, 0);
        else check(pLow == parkQ.pop_front(), "R4 park width", pLow, int'(PARK_EXP + RESET_EXP + 1));
        pLow = 0;
      end
      if (!ctrlRstN) rLow++;
      else if (rLow > 0) begin
        if (rstQ.size() == 0) check(0, "R6 unexpected reset pulse", rLow, 0);
        else check(rLow == rstQ.pop_front(), "R4 R9 reset width", rLow, int'(RESET_EXP));
        rLow = 0;
      end
    end
  end

  initial begin
    repeat (200_000) @(posedge clk);
    if (!finished) begin
      check(0, "watchdog", 0, 1);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    sysReset();
    // R1 reset state
    check(parkN == 1, "R1 parkN", parkN, 1);
    check(ctrlRstN == 1, "R1 ctrlRstN", ctrlRstN, 1);
    check(pwrGood == 1, "R1 pwrGood", pwrGood, 1);
    check(safeToRemove == 0, "R1 safe", safeToRemove, 0);
    check(holdUp == 0, "R1 holdUp", holdUp, 0);
    check(busy == 0, "R1 busy", busy, 0);
    check(errFlag == 0, "R1 err", errFlag, 0);

    // R4 R9 restart, with requests during busy (R6, R10)
    parkQ.push_back(int'(PARK_EXP + RESET_EXP + 1));
    rstQ.push_back(int'(RESET_EXP));
    pulse(0, 1);
    waitCyc(int'(PARK_EXP) + 20);
    check(busy == 1, "R10 busy in reset phase", busy, 1);
    check(ctrlRstN == 0 && parkN == 0, "R4 reset inside park", ctrlRstN, 0);
    pulse(1, 1);
    waitIdle(10_000);
    waitCyc(2);
    check(parkN == 1, "R4 park released", parkN, 1);
    check(safeToRemove == 0, "R6 power-down ignored", safeToRemove, 0);
    waitCyc(200);
    check(parkN == 1 && busy == 0, "R6 restart ignored", parkN, 1);
    check(parkQ.size() == 0 && rstQ.size() == 0, "R4 scoreboard drained",
          parkQ.size() + rstQ.size(), 0);

    // R2 R3 planned power-down, power-enable drops early
    pulse(1, 0);
    waitCyc(9);
    ctrlPwrEn = 1'b0;
    waitCyc(int'(PARK_EXP) - 11);
    check(parkN == 0 && busy == 1, "R2 park held", parkN, 0);
    check(safeToRemove == 0, "R3 safe not in park window", safeToRemove, 0);
    waitCyc(4);
    check(safeToRemove == 1, "R3 safe after window", safeToRemove, 1);
    check(busy == 0 && parkN == 0, "R2 R10 park held when done", parkN, 0);
    sysReset();

    // R6 both strobes together in idle: power-down wins
    pulse(1, 1);
    waitCyc(int'(PARK_EXP) + 30);
    check(ctrlRstN == 1, "R6 power-down priority", ctrlRstN, 1);
    check(errFlag == 1, "R8 timeout error", errFlag, 1);
    ctrlPwrEn = 1'b0;
    waitCyc(10);
    check(safeToRemove == 0 && errFlag == 1, "R8 error sticky", safeToRemove, 0);
    sysReset();

    // R7 power failure in the middle of a power-down park window
    pulse(1, 0);
    waitCyc(15);
    powerFail = 1'b1;
    begin
      int hu;
      hu = 0;
      for (int i = 0; i < 10 && !holdUp; i++) @(negedge clk);
      check(pwrGood == 0, "R7 pwrGood dropped", pwrGood, 0);
      while (holdUp && hu < 1000) begin
        hu++;
        @(negedge clk);
      end
      check(hu == int'(PARK_EXP), "R7 holdUp cycles", hu, int'(PARK_EXP));
    end
    check(parkN == 0 && busy == 1, "R7 waiting for power-enable", busy, 1);
    powerFail = 1'b0;
    ctrlPwrEn = 1'b0;
    waitCyc(6);
    check(safeToRemove == 1, "R7 safe after power-enable", safeToRemove, 1);
    check(pwrGood == 0, "R7 pwrGood sticky", pwrGood, 0);
    sysReset();
    check(parkN == 1 && pwrGood == 1, "R1 second reset", parkN, 1);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule